// File: doc/BRIEF.md
# Trapping Integer ALU with Carry Flag

This block is the integer arithmetic and logic stage for the register-to-register operations of a stack-oriented processor. Each request supplies two 32-bit operands and a 4-bit operation code, qualified by a valid strobe. The block holds one architectural carry flag. It returns a registered 32-bit result and the updated carry, and it raises separate trap indications for signed overflow, tag errors and bounds-check failure.

The add and subtract family has four flavours. They differ in whether the carry feeds in, how the carry is updated afterwards, and which traps apply. The tag check treats a word as malformed when its two most significant bits disagree. Bitwise AND, OR and XOR and a bounds check complete the set.

A small state machine records the outcome of the previous cycle. In **ST_IDLE** no request was taken. In **ST_DONE** a request was committed. In **ST_TRAP** a request trapped. From every state the next state is chosen by the current cycle alone:
- **GO_TRAP**: a valid request that traps.
- **GO_DONE**: a valid request that does not trap.
- **GO_IDLE**: no valid request.

The trap outputs are decoded from ST_TRAP and a latched cause vector.

Top module: `trap_alu`

## Requirements
- R1: After reset the result is 0, the carry is 0 and all three trap outputs are 0.
- R2: A request is taken when in_valid is high at a rising clock edge, and the outputs reflect it right after that edge. When in_valid is low, the result and carry do not change and no trap output is raised.
- R3: Code 0 gives A+B and code 1 gives A-B. Neither uses the carry, both leave it unchanged, and neither traps.
- R4: Code 2 gives A+B+C and code 3 gives A-B-C, where C is the carry. Both clear the carry. Both raise trap_ovf on signed overflow. Overflow means the addends share a sign and the sum has the other sign; for subtraction the second addend is the complement of B.
- R5: Code 4 gives A+B+C and loads the carry with the adder carry-out. Code 5 gives A-B-C and loads the carry with the inverted carry-out (the borrow). Neither ever traps.
- R6: Code 6 gives A+B and code 7 gives A-B, with no carry-in. Both clear the carry and raise trap_ovf on signed overflow. They raise trap_nan when bits 31 and 30 differ in A, in B or in the result. Both traps may rise together.
- R7: Code 8 is AND, code 9 is OR and code 10 is XOR. They never trap and leave the carry unchanged.
- R8: Code 11 is a bounds check. It raises trap_bound when A bit 31 is set, or when bit 31 of the 32-bit difference A-B is clear. Otherwise the result becomes A. The carry is unchanged. So with B = 0x80000000 it traps exactly when A is negative.
- R9: On any trap the result and carry keep their previous values. Each raised trap output is high for exactly the one cycle after the request.
- R10: Codes 12 to 15 change neither result nor carry and raise no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| result | output | 32 | Registered result |
| carry | output | 1 | Architectural carry flag |
| trap_ovf | output | 1 | Signed overflow trap |
| trap_nan | output | 1 | Tag (two top bits differ) trap |
| trap_bound | output | 1 | Bounds-check trap |

## Verification
Signed overflow and the tag error can fall in the same cycle in the Lisp-style add and subtract. The bench provokes this by adding 1 to 0x7FFFFFFF: the first operand is already malformed, and the sum both overflows and is malformed. Both trap_ovf and trap_nan must then be high in the same cycle, with result and carry held. Single-cause cases, where only the tag is bad, are checked next to it so that one flag cannot simply mirror the other.

// File: rtl/trap_alu_pkg.sv
package trap_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_VADD = 4'd0,
        OP_VSUB = 4'd1,
        OP_SADD = 4'd2,
        OP_SSUB = 4'd3,
        OP_UADD = 4'd4,
        OP_USUB = 4'd5,
        OP_LADD = 4'd6,
        OP_LSUB = 4'd7,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_BCHK = 4'd11
    } op_e;

    typedef enum logic [1:0] {K_NONE, K_ARITH, K_LOGIC, K_BOUND} kind_e;
    typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_CY, CIN_NCY} cin_e;
    typedef enum logic [1:0] {CY_KEEP, CY_CLEAR, CY_COUT, CY_NCOUT} cy_e;
    typedef enum logic [1:0] {FN_AND, FN_OR, FN_XOR, FN_NONE} fn_e;
    typedef enum logic [1:0] {ST_IDLE, ST_DONE, ST_TRAP} state_e;

    typedef struct packed {
        kind_e kind;
        logic  sub;
        cin_e  cin;
        cy_e   cy;
        logic  chk_ovf;
        logic  chk_nan;
        fn_e   fn;
    } ctl_t;

endpackage

// File: rtl/trap_alu_dec.sv
module trap_alu_dec
    import trap_alu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output ctl_t            ctl
);
    always_comb begin
        ctl = '{kind: K_NONE, sub: 1'b0, cin: CIN_ZERO, cy: CY_KEEP,
                chk_ovf: 1'b0, chk_nan: 1'b0, fn: FN_NONE};
        unique case (op)
            OP_VADD: ctl.kind = K_ARITH;
            OP_VSUB: begin
                ctl.kind = K_ARITH; ctl.sub = 1'b1; ctl.cin = CIN_ONE;
            end
            OP_SADD: begin
                ctl.kind = K_ARITH; ctl.cin = CIN_CY;
                ctl.cy = CY_CLEAR; ctl.chk_ovf = 1'b1;
            end
            OP_SSUB: begin
                ctl.kind = K_ARITH; ctl.sub = 1'b1; ctl.cin = CIN_NCY;
                ctl.cy = CY_CLEAR; ctl.chk_ovf = 1'b1;
            end
            OP_UADD: begin
                ctl.kind = K_ARITH; ctl.cin = CIN_CY; ctl.cy = CY_COUT;
            end
            OP_USUB: begin
                ctl.kind = K_ARITH; ctl.sub = 1'b1; ctl.cin = CIN_NCY;
                ctl.cy = CY_NCOUT;
            end
            OP_LADD: begin
                ctl.kind = K_ARITH; ctl.cy = CY_CLEAR;
                ctl.chk_ovf = 1'b1; ctl.chk_nan = 1'b1;
            end
            OP_LSUB: begin
                ctl.kind = K_ARITH; ctl.sub = 1'b1; ctl.cin = CIN_ONE;
                ctl.cy = CY_CLEAR; ctl.chk_ovf = 1'b1; ctl.chk_nan = 1'b1;
            end
            OP_AND: begin ctl.kind = K_LOGIC; ctl.fn = FN_AND; end
            OP_OR:  begin ctl.kind = K_LOGIC; ctl.fn = FN_OR;  end
            OP_XOR: begin ctl.kind = K_LOGIC; ctl.fn = FN_XOR; end
            OP_BCHK: begin
                ctl.kind = K_BOUND; ctl.sub = 1'b1; ctl.cin = CIN_ONE;
            end
            default: ctl.kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/trap_alu_addsub.sv
module trap_alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             invert_b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_eff = invert_b ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
        sum   = wide[WIDTH-1:0];
        cout  = wide[WIDTH];
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/trap_alu_tagchk.sv
module trap_alu_tagchk #(
    parameter int WIDTH = 32,
    parameter int WORDS = 3
) (
    input  logic [WORDS-1:0][WIDTH-1:0] words,
    output logic                        bad
);
    logic [WORDS-1:0] per_word;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        assign per_word[i] = words[i][WIDTH-1] ^ words[i][WIDTH-2];
    end

    assign bad = |per_word;
endmodule

// File: rtl/trap_alu.sv
module trap_alu
    import trap_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] result,
    output logic             carry,
    output logic             trap_ovf,
    output logic             trap_nan,
    output logic             trap_bound
);
    localparam int MSB    = WIDTH - 1;
    localparam int N_TAGW = 3;

    ctl_t             ctl;
    logic             cin;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic             ovf;
    logic             tag_bad;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] next_res;
    logic             next_cy;
    logic [2:0]       cause;
    logic             trap_any;

    state_e           state_q, state_d;
    logic [WIDTH-1:0] res_q;
    logic             cy_q;
    logic [2:0]       cause_q;

    trap_alu_dec u_dec (
        .op  (op),
        .ctl (ctl)
    );

    always_comb begin
        unique case (ctl.cin)
            CIN_ZERO: cin = 1'b0;
            CIN_ONE:  cin = 1'b1;
            CIN_CY:   cin = cy_q;
            CIN_NCY:  cin = ~cy_q;
        endcase
    end

    trap_alu_addsub #(.WIDTH(WIDTH)) u_add (
        .a        (a),
        .b        (b),
        .invert_b (ctl.sub),
        .cin      (cin),
        .sum      (sum),
        .cout     (cout),
        .ovf      (ovf)
    );

    trap_alu_tagchk #(.WIDTH(WIDTH), .WORDS(N_TAGW)) u_tag (
        .words ({a, b, sum}),
        .bad   (tag_bad)
    );

    always_comb begin
        unique case (ctl.fn)
            FN_AND:  logic_res = a & b;
            FN_OR:   logic_res = a | b;
            FN_XOR:  logic_res = a ^ b;
            FN_NONE: logic_res = res_q;
        endcase
    end

    always_comb begin
        unique case (ctl.kind)
            K_ARITH: next_res = sum;
            K_LOGIC: next_res = logic_res;
            K_BOUND: next_res = a;
            K_NONE:  next_res = res_q;
        endcase
        unique case (ctl.cy)
            CY_KEEP:  next_cy = cy_q;
            CY_CLEAR: next_cy = 1'b0;
            CY_COUT:  next_cy = cout;
            CY_NCOUT: next_cy = ~cout;
        endcase
        // cause bits: [0] overflow, [1] tag, [2] bounds
        cause[0] = ctl.chk_ovf & ovf;
        cause[1] = ctl.chk_nan & tag_bad;
        cause[2] = (ctl.kind == K_BOUND) & (a[MSB] | ~sum[MSB]);
        trap_any = |cause;
    end

    // next-state selection: GO_TRAP / GO_DONE / GO_IDLE
    always_comb begin
        if (in_valid && trap_any)  state_d = ST_TRAP;
        else if (in_valid)         state_d = ST_DONE;
        else                       state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= '0;
            cy_q    <= 1'b0;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_TRAP) begin
                cause_q <= cause;
            end
            if (state_d == ST_DONE) begin
                res_q <= next_res;
                cy_q  <= next_cy;
            end
        end
    end

    always_comb begin
        result     = res_q;
        carry      = cy_q;
        trap_ovf   = 1'b0;
        trap_nan   = 1'b0;
        trap_bound = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: ;
            ST_TRAP: begin
                trap_ovf   = cause_q[0];
                trap_nan   = cause_q[1];
                trap_bound = cause_q[2];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/trap_alu_chk.sv
module trap_alu_chk
    import trap_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [OP_W-1:0]  op,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] result,
    input logic             carry,
    input logic             trap_ovf,
    input logic             trap_nan,
    input logic             trap_bound
);
    logic any_trap;
    assign any_trap = trap_ovf | trap_nan | trap_bound;

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !any_trap && $stable(result) && $stable(carry));

    p_vanilla_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op == OP_VADD || op == OP_VSUB) |=> !any_trap && $stable(carry));

    p_unsigned_notrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op == OP_UADD || op == OP_USUB) |=> !any_trap);

    p_lisp_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op == OP_LADD || op == OP_LSUB) |=> any_trap || !carry);

    p_logic_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op == OP_AND || op == OP_OR || op == OP_XOR) |=> !any_trap && $stable(carry));

    p_bound_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == OP_BCHK |=> trap_bound || result == $past(a));

    p_bound_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_bound |-> !trap_ovf && !trap_nan);

    p_trap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any_trap |-> $stable(result) && $stable(carry));

    p_trap_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any_trap && !in_valid |=> !any_trap);

    p_undef_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op > OP_BCHK |=> !any_trap && $stable(result) && $stable(carry));
endmodule

bind trap_alu trap_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op         (op),
    .a          (a),
    .result     (result),
    .carry      (carry),
    .trap_ovf   (trap_ovf),
    .trap_nan   (trap_nan),
    .trap_bound (trap_bound)
);

// File: tb/test_trap_alu.sv
module test_trap_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [31:0] result;
    logic        carry, trap_ovf, trap_nan, trap_bound;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    trap_alu i_trap_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
        .result(result), .carry(carry), .trap_ovf(trap_ovf),
        .trap_nan(trap_nan), .trap_bound(trap_bound)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic expect_all(input string req, input logic [31:0] e_res, input logic e_cy,
                              input logic e_ovf, input logic e_nan, input logic e_bnd);
        check(req, "result", result, e_res);
        check(req, "carry", {31'b0, carry}, {31'b0, e_cy});
        check(req, "traps", {29'b0, trap_ovf, trap_nan, trap_bound},
              {29'b0, e_ovf, e_nan, e_bnd});
    endtask

    // one valid request, then sample at the following falling edge
    task automatic issue(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
        @(negedge clk);
        in_valid = 1'b1; op = o; a = x; b = y;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic set_carry();
        issue(4'd4, 32'hFFFF_FFFF, 32'h1);  // carry was anything: sum 0 or 1, carry 1
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_all("R1", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        in_valid = 1'b0; op = 4'd0; a = 32'h1; b = 32'h2;
        @(negedge clk);
        expect_all("R2", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_unsigned();
        issue(4'd4, 32'hFFFF_FFFF, 32'h1); expect_all("R5", 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
        issue(4'd4, 32'h2, 32'h3);         expect_all("R5", 32'h6, 1'b0, 1'b0, 1'b0, 1'b0);
        issue(4'd5, 32'h3, 32'h5);         expect_all("R5", 32'hFFFF_FFFE, 1'b1, 1'b0, 1'b0, 1'b0);
        issue(4'd5, 32'hA, 32'h3);         expect_all("R5", 32'h6, 1'b0, 1'b0, 1'b0, 1'b0);
        issue(4'd4, 32'h7FFF_FFFF, 32'h1); expect_all("R5", 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_vanilla();
        set_carry();
        issue(4'd0, 32'h5, 32'h6); expect_all("R3", 32'hB, 1'b1, 1'b0, 1'b0, 1'b0);
        issue(4'd1, 32'h5, 32'h6); expect_all("R3", 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_signed();
        issue(4'd2, 32'h5, 32'h3);         expect_all("R4", 32'h9, 1'b0, 1'b0, 1'b0, 1'b0);
        issue(4'd3, 32'hA, 32'h3);         expect_all("R4", 32'h7, 1'b0, 1'b0, 1'b0, 1'b0);
        issue(4'd2, 32'h7FFF_FFFF, 32'h1); expect_all("R4 R9", 32'h7, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);                    expect_all("R9", 32'h7, 1'b0, 1'b0, 1'b0, 1'b0);
        set_carry();
        issue(4'd3, 32'h8000_0000, 32'h1); expect_all("R4 R9", 32'h0, 1'b1, 1'b1, 1'b0, 1'b0);
        issue(4'd3, 32'h8000_0000, 32'hFFFF_FFFF);
        expect_all("R4", 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_lisp();
        set_carry();
        issue(4'd6, 32'h3, 32'h4);         expect_all("R6", 32'h7, 1'b0, 1'b0, 1'b0, 1'b0);
        issue(4'd7, 32'h2000_0000, 32'h3000_0000);
        expect_all("R6", 32'hF000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
        issue(4'd6, 32'h4000_0000, 32'h0); expect_all("R6", 32'hF000_0000, 1'b0, 1'b0, 1'b1, 1'b0);
        issue(4'd6, 32'h3FFF_FFFF, 32'h1); expect_all("R6", 32'hF000_0000, 1'b0, 1'b0, 1'b1, 1'b0);
        issue(4'd7, 32'h5, 32'hBFFF_FFFF); expect_all("R6", 32'hF000_0000, 1'b0, 1'b0, 1'b1, 1'b0);
        issue(4'd6, 32'h7FFF_FFFF, 32'h1); expect_all("R6", 32'hF000_0000, 1'b0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_logic();
        set_carry();
        issue(4'd8,  32'hF0F0_F0F0, 32'hFF00_FF00); expect_all("R7", 32'hF000_F000, 1'b1, 1'b0, 1'b0, 1'b0);
        issue(4'd9,  32'hF0F0_F0F0, 32'hFF00_FF00); expect_all("R7", 32'hFFF0_FFF0, 1'b1, 1'b0, 1'b0, 1'b0);
        issue(4'd10, 32'hF0F0_F0F0, 32'hFF00_FF00); expect_all("R7", 32'h0FF0_0FF0, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_bound();
        issue(4'd11, 32'h5, 32'hA);                 expect_all("R8", 32'h5, 1'b1, 1'b0, 1'b0, 1'b0);
        issue(4'd11, 32'hA, 32'hA);                 expect_all("R8", 32'h5, 1'b1, 1'b0, 1'b0, 1'b1);
        issue(4'd11, 32'hFFFF_FFFF, 32'h8000_0000); expect_all("R8", 32'h5, 1'b1, 1'b0, 1'b0, 1'b1);
        issue(4'd11, 32'h7, 32'h8000_0000);         expect_all("R8", 32'h7, 1'b1, 1'b0, 1'b0, 1'b0);
        issue(4'd11, 32'hFFFF_FFFF, 32'h5);         expect_all("R8", 32'h7, 1'b1, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_undef();
        issue(4'd13, 32'h1, 32'h1); expect_all("R10", 32'h7, 1'b1, 1'b0, 1'b0, 1'b0);
        issue(4'd15, 32'h4000_0000, 32'hFFFF_FFFF);
        expect_all("R10", 32'h7, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_unsigned();
        t_vanilla();
        t_signed();
        t_lisp();
        t_logic();
        t_bound();
        t_undef();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule